// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block drives the control lines of a 16-bit multicycle datapath. That datapath has a register file, operand latches A and B, a result latch C, a memory data latch, an instruction latch and a program counter. A 3-bit step counter tracks the progress of the current instruction. The 6-bit opcode, taken from the top of the instruction latch, is decoded into an instruction class. The class and the step together select every write enable, every multiplexer select, the ALU function and the memory write line for the current cycle.

Each instruction begins with a shared fetch step, and the PC is always updated from C in step 1. After that, each class follows its own schedule. Instructions that carry a 16-bit immediate read it as the next memory word, so they spend additional steps moving the PC past that word. A conditional PC write is not decided here. The block only indicates which value of the datapath's zero flag permits the write, and the datapath applies that condition. Opcodes that are not recognised end after step 1, and a new fetch begins.

Top module: `mcs_ctrl_seq`

## Requirements
- R1: An active-low asynchronous reset clears the step counter to 0. Step 0 is the fetch step for every instruction: ir_we=1, c_we=1, alu_a_sel=1 (PC), alu_b_sel=2 (constant 1), alu_op=0 (add), maddr_sel=0 (PC). All other lines are 0.
- R2: In step 1 every opcode asserts pc_we with pc_sel=0 (from C) and use_z=0 (unconditional).
- R3: R-format (add 000000, and 000001, or 000010, xor 000011, sub 001000, slt 001100) runs 4 steps. Step 1 loads A and B. Step 2 loads C with the ALU applied to A and B. Step 3 writes C into the register selected by rs (rf_we=1, wr_rt=0, rf_wsel=0).
- R4: Immediate ALU ops (addi 010000, andi 010001, ori 010010, xori 010011, subi 011000) run 5 steps. Step 1 loads A and loads MDR from memory at C (maddr_sel=1). Step 2 loads C with A op MDR (alu_b_sel=1). Step 3 writes C into rt (wr_rt=1) and also loads C with PC+1. Step 4 loads the PC.
- R5: ld (100000) runs 4 steps. Step 2 loads MDR from memory at A (maddr_sel=2), and step 3 writes MDR into rt (rf_wsel=1). ldi (100001) runs 5 steps. It fetches the immediate in step 1 and adds A+MDR into C in step 2. Step 3 loads C with PC+1 and MDR from memory at C. Step 4 writes MDR into rt and loads the PC.
- R6: st (100010) runs 3 steps and writes memory at A in step 2 (mem_wr=1). sti (100011) runs 5 steps. Step 2 computes A+MDR into C and loads B. Step 3 writes memory at C and loads C with PC+1. Step 4 loads the PC.
- R7: bt (110000) and bf (110001) run 4 steps. Step 1 reads register 0 into A (rd1_zero=1) together with rt into B. Step 2 computes A−B (alu_op=4) and reloads A from rs. Step 3 loads the PC from A (pc_sel=1). The write is allowed only when the zero flag is clear for bt (use_z=2) and only when it is set for bf (use_z=1).
- R8: beq (110100) and bne (110101) run 7 steps. The sequence is: step 1 loads A, B and MDR from memory at C; step 2 loads C with PC+1; step 3 loads the PC; step 4 loads C with PC+MDR; step 5 computes A−B with no latch written. Step 6 loads the PC from C when the zero flag is set for beq (use_z=1) and when it is clear for bne (use_z=2).
- R9: Any other opcode runs 2 steps. Step 1 performs only the PC update, and the counter then returns to the fetch step.
- R10: The ALU function encodings are add 0, and 1, or 2, xor 3, sub 4, slt 5.
- R11: Every enable, select and ALU field that a step does not use is driven to 0.
- R12: The step counter advances by one each cycle and returns to 0 in the cycle after a class's final step. It never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction latch |
| step | output | 3 | Current step of the instruction |
| a_we | output | 1 | Load operand latch A |
| b_we | output | 1 | Load operand latch B |
| c_we | output | 1 | Load result latch C |
| pc_we | output | 1 | PC write request (qualified by use_z) |
| rf_we | output | 1 | Register file write |
| ir_we | output | 1 | Load instruction latch |
| mdr_we | output | 1 | Load memory data latch |
| mem_wr | output | 1 | Memory write (0 = read) |
| alu_a_sel | output | 1 | ALU input A: 0 latch A, 1 PC |
| alu_b_sel | output | 2 | ALU input B: 0 latch B, 1 MDR, 2 constant 1 |
| rf_wsel | output | 1 | Register write data: 0 C, 1 MDR |
| pc_sel | output | 1 | PC source: 0 C, 1 latch A |
| maddr_sel | output | 2 | Memory address: 0 PC, 1 C, 2 latch A |
| use_z | output | 2 | PC write condition: 0 always, 1 zero set, 2 zero clear |
| rd1_zero | output | 1 | First read port reads register 0 instead of rs |
| wr_rt | output | 1 | Register write target: 0 rs, 1 rt |
| alu_op | output | 4 | ALU function |

## Verification
The bench builds the block with its package widths: a 6-bit opcode, a 3-bit step counter and a 4-bit ALU function. These widths cover the longest schedule, the 7-step branch-compare, and every opcode slot. The directed tasks step through each class one cycle at a time and compare the complete control word against a schedule written out independently. They run every legal opcode, sample unassigned opcodes from each opcode quadrant, and apply a reset in the middle of a branch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int OPC_W   = 6;
  localparam int STEP_W  = 3;
  localparam int ALUOP_W = 4;

  typedef enum logic [3:0] {
    CL_RTYPE, CL_IMM, CL_LD, CL_LDI, CL_ST, CL_STI, CL_BRT, CL_BRC, CL_BAD
  } op_class_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 4'd0, ALU_AND = 4'd1, ALU_OR = 4'd2,
    ALU_XOR = 4'd3, ALU_SUB = 4'd4, ALU_SLT = 4'd5
  } alu_op_e;

  typedef enum logic       { AA_REG = 1'b0, AA_PC = 1'b1 } alu_a_e;
  typedef enum logic [1:0] { AB_REG = 2'd0, AB_MDR = 2'd1, AB_ONE = 2'd2 } alu_b_e;
  typedef enum logic       { RW_C = 1'b0, RW_MDR = 1'b1 } rf_src_e;
  typedef enum logic       { PS_C = 1'b0, PS_A = 1'b1 } pc_src_e;
  typedef enum logic [1:0] { MA_PC = 2'd0, MA_C = 2'd1, MA_A = 2'd2 } maddr_e;
  typedef enum logic [1:0] { UZ_ALWAYS = 2'd0, UZ_IF_SET = 2'd1, UZ_IF_CLR = 2'd2 } usez_e;

  typedef struct packed {
    logic    a_we;
    logic    b_we;
    logic    c_we;
    logic    pc_we;
    logic    rf_we;
    logic    ir_we;
    logic    mdr_we;
    logic    mem_wr;
    alu_a_e  alu_a;
    alu_b_e  alu_b;
    rf_src_e rf_src;
    pc_src_e pc_src;
    maddr_e  maddr;
    usez_e   use_z;
    logic    rd1_zero;
    logic    wr_rt;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic ctrl_t ctrl_idle();
    ctrl_t c;
    c = '0;
    return c;
  endfunction

  // ALU function from the low four opcode bits shared by register and immediate forms
  function automatic alu_op_e alu_from_func(input logic [3:0] f);
    case (f)
      4'b0001: return ALU_AND;
      4'b0010: return ALU_OR;
      4'b0011: return ALU_XOR;
      4'b1000: return ALU_SUB;
      4'b1100: return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  // Index of the final step for each class
  function automatic logic [STEP_W-1:0] final_step(input op_class_e c);
    case (c)
      CL_RTYPE, CL_LD, CL_BRT:  return STEP_W'(3);
      CL_IMM, CL_LDI, CL_STI:   return STEP_W'(4);
      CL_ST:                    return STEP_W'(2);
      CL_BRC:                   return STEP_W'(6);
      default:                  return STEP_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output op_class_e         op_class,
  output alu_op_e           fn_op,
  output logic              z_when_set,
  output logic [STEP_W-1:0] last_step
);

  logic [1:0] quad;
  logic [3:0] low;
  logic       r_ok;
  logic       i_ok;

  assign quad = opcode[OPC_W-1 -: 2];
  assign low  = opcode[3:0];

  assign r_ok = (low inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1000, 4'b1100});
  assign i_ok = (low inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b1000});

  always_comb begin
    op_class = CL_BAD;
    case (quad)
      2'b00: if (r_ok) op_class = CL_RTYPE;
      2'b01: if (i_ok) op_class = CL_IMM;
      2'b10: begin
        if (low[3:2] == 2'b00) begin
          case (low[1:0])
            2'b00:   op_class = CL_LD;
            2'b01:   op_class = CL_LDI;
            2'b10:   op_class = CL_ST;
            default: op_class = CL_STI;
          endcase
        end
      end
      default: begin
        if (!low[3] && !low[1])
          op_class = low[2] ? CL_BRC : CL_BRT;
      end
    endcase
  end

  assign fn_op      = alu_from_func(low);
  // bf and beq write the PC when the zero flag is set; bt and bne when it is clear
  assign z_when_set = opcode[0] ^ opcode[2];
  assign last_step  = final_step(op_class);

endmodule

// File: rtl/mcs_step_ctr.sv
module mcs_step_ctr
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] last_step,
  output logic [STEP_W-1:0] step,
  output logic              wrap
);

  assign wrap = (step == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step <= '0;
    else if (wrap) step <= '0;
    else           step <= step + 1'b1;
  end

endmodule

// File: rtl/mcs_ctrl_table.sv
module mcs_ctrl_table
  import mcs_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  op_class_e         op_class,
  input  alu_op_e           fn_op,
  input  logic              z_when_set,
  output ctrl_t             ctrl
);

  usez_e cond;
  assign cond = z_when_set ? UZ_IF_SET : UZ_IF_CLR;

  always_comb begin
    ctrl = ctrl_idle();
    case (step)
      STEP_W'(0): begin
        ctrl.ir_we  = 1'b1;
        ctrl.c_we   = 1'b1;
        ctrl.alu_a  = AA_PC;
        ctrl.alu_b  = AB_ONE;
        ctrl.alu_op = ALU_ADD;
        ctrl.maddr  = MA_PC;
      end
      STEP_W'(1): begin
        ctrl.pc_we  = 1'b1;
        ctrl.pc_src = PS_C;
        case (op_class)
          CL_RTYPE, CL_ST: begin
            ctrl.a_we = 1'b1;
            ctrl.b_we = 1'b1;
          end
          CL_IMM, CL_LDI, CL_STI: begin
            ctrl.a_we   = 1'b1;
            ctrl.mdr_we = 1'b1;
            ctrl.maddr  = MA_C;
          end
          CL_LD: ctrl.a_we = 1'b1;
          CL_BRT: begin
            ctrl.a_we     = 1'b1;
            ctrl.b_we     = 1'b1;
            ctrl.rd1_zero = 1'b1;
          end
          CL_BRC: begin
            ctrl.a_we   = 1'b1;
            ctrl.b_we   = 1'b1;
            ctrl.mdr_we = 1'b1;
            ctrl.maddr  = MA_C;
          end
          default: ;
        endcase
      end
      STEP_W'(2): begin
        case (op_class)
          CL_RTYPE: begin
            ctrl.c_we   = 1'b1;
            ctrl.alu_op = fn_op;
          end
          CL_IMM: begin
            ctrl.c_we   = 1'b1;
            ctrl.alu_b  = AB_MDR;
            ctrl.alu_op = fn_op;
          end
          CL_LD: begin
            ctrl.mdr_we = 1'b1;
            ctrl.maddr  = MA_A;
          end
          CL_LDI: begin
            ctrl.c_we  = 1'b1;
            ctrl.alu_b = AB_MDR;
          end
          CL_ST: begin
            ctrl.mem_wr = 1'b1;
            ctrl.maddr  = MA_A;
          end
          CL_STI: begin
            ctrl.c_we  = 1'b1;
            ctrl.b_we  = 1'b1;
            ctrl.alu_b = AB_MDR;
          end
          CL_BRT: begin
            ctrl.a_we   = 1'b1;
            ctrl.alu_op = ALU_SUB;
          end
          CL_BRC: begin
            ctrl.c_we  = 1'b1;
            ctrl.alu_a = AA_PC;
            ctrl.alu_b = AB_ONE;
          end
          default: ;
        endcase
      end
      STEP_W'(3): begin
        case (op_class)
          CL_RTYPE: ctrl.rf_we = 1'b1;
          CL_IMM: begin
            ctrl.rf_we = 1'b1;
            ctrl.wr_rt = 1'b1;
            ctrl.c_we  = 1'b1;
            ctrl.alu_a = AA_PC;
            ctrl.alu_b = AB_ONE;
          end
          CL_LD: begin
            ctrl.rf_we  = 1'b1;
            ctrl.wr_rt  = 1'b1;
            ctrl.rf_src = RW_MDR;
          end
          CL_LDI: begin
            ctrl.c_we   = 1'b1;
            ctrl.alu_a  = AA_PC;
            ctrl.alu_b  = AB_ONE;
            ctrl.mdr_we = 1'b1;
            ctrl.maddr  = MA_C;
          end
          CL_STI: begin
            ctrl.mem_wr = 1'b1;
            ctrl.maddr  = MA_C;
            ctrl.c_we   = 1'b1;
            ctrl.alu_a  = AA_PC;
            ctrl.alu_b  = AB_ONE;
          end
          CL_BRT: begin
            ctrl.pc_we  = 1'b1;
            ctrl.pc_src = PS_A;
            ctrl.use_z  = cond;
          end
          CL_BRC: ctrl.pc_we = 1'b1;
          default: ;
        endcase
      end
      STEP_W'(4): begin
        case (op_class)
          CL_IMM, CL_STI: ctrl.pc_we = 1'b1;
          CL_LDI: begin
            ctrl.rf_we  = 1'b1;
            ctrl.wr_rt  = 1'b1;
            ctrl.rf_src = RW_MDR;
            ctrl.pc_we  = 1'b1;
          end
          CL_BRC: begin
            ctrl.c_we  = 1'b1;
            ctrl.alu_a = AA_PC;
            ctrl.alu_b = AB_MDR;
          end
          default: ;
        endcase
      end
      STEP_W'(5): begin
        if (op_class == CL_BRC) ctrl.alu_op = ALU_SUB;
      end
      STEP_W'(6): begin
        if (op_class == CL_BRC) begin
          ctrl.pc_we = 1'b1;
          ctrl.use_z = cond;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mcs_ctrl_seq.sv
module mcs_ctrl_seq
  import mcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPC_W-1:0]    opcode,
  output logic [STEP_W-1:0]   step,
  output logic                a_we,
  output logic                b_we,
  output logic                c_we,
  output logic                pc_we,
  output logic                rf_we,
  output logic                ir_we,
  output logic                mdr_we,
  output logic                mem_wr,
  output logic                alu_a_sel,
  output logic [1:0]          alu_b_sel,
  output logic                rf_wsel,
  output logic                pc_sel,
  output logic [1:0]          maddr_sel,
  output logic [1:0]          use_z,
  output logic                rd1_zero,
  output logic                wr_rt,
  output logic [ALUOP_W-1:0]  alu_op
);

  op_class_e         op_class;
  alu_op_e           fn_op;
  logic              z_when_set;
  logic [STEP_W-1:0] last_step;
  logic              wrap;
  ctrl_t             ctrl;

  mcs_decode u_decode (
    .opcode     (opcode),
    .op_class   (op_class),
    .fn_op      (fn_op),
    .z_when_set (z_when_set),
    .last_step  (last_step)
  );

  mcs_step_ctr u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .last_step (last_step),
    .step      (step),
    .wrap      (wrap)
  );

  mcs_ctrl_table u_table (
    .step       (step),
    .op_class   (op_class),
    .fn_op      (fn_op),
    .z_when_set (z_when_set),
    .ctrl       (ctrl)
  );

  assign a_we      = ctrl.a_we;
  assign b_we      = ctrl.b_we;
  assign c_we      = ctrl.c_we;
  assign pc_we     = ctrl.pc_we;
  assign rf_we     = ctrl.rf_we;
  assign ir_we     = ctrl.ir_we;
  assign mdr_we    = ctrl.mdr_we;
  assign mem_wr    = ctrl.mem_wr;
  assign alu_a_sel = ctrl.alu_a;
  assign alu_b_sel = ctrl.alu_b;
  assign rf_wsel   = ctrl.rf_src;
  assign pc_sel    = ctrl.pc_src;
  assign maddr_sel = ctrl.maddr;
  assign use_z     = ctrl.use_z;
  assign rd1_zero  = ctrl.rd1_zero;
  assign wr_rt     = ctrl.wr_rt;
  assign alu_op    = ctrl.alu_op;

  // R1: the fetch step loads IR and C from PC, never writes memory or PC
  a_r1_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |-> (ir_we && c_we && maddr_sel == MA_PC && !mem_wr && !pc_we));

  // R1: the instruction latch is only loaded during fetch
  a_r1_ir_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |-> (step == '0));

  // R2: step 1 always moves C into the PC unconditionally
  a_r2_step1_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(1)) |-> (pc_we && pc_sel == PS_C && use_z == UZ_ALWAYS));

  // R6: memory writes only for store classes and never at the PC address
  a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ((op_class == CL_ST || op_class == CL_STI) && maddr_sel != MA_PC));

  // R7 / R8: a conditional PC write is a branch-class PC write
  a_r7_cond_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (use_z != UZ_ALWAYS) |-> (pc_we && (op_class == CL_BRT || op_class == CL_BRC)));

  // R9: an unknown opcode returns to fetch after step 1
  a_r9_bad_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (step == STEP_W'(1) && op_class == CL_BAD) |=> (step == '0));

  // R12: the step counter stays within the longest schedule
  a_r12_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= STEP_W'(6));

  // R12: the step after a final step is fetch
  a_r12_wrap_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ir_we);

endmodule

// File: tb/mcs_ctrl_seq_tb.sv
module mcs_ctrl_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;

  logic [2:0] step;
  logic a_we, b_we, c_we, pc_we, rf_we, ir_we, mdr_we, mem_wr;
  logic       alu_a_sel, rf_wsel, pc_sel, rd1_zero, wr_rt;
  logic [1:0] alu_b_sel, maddr_sel, use_z;
  logic [3:0] alu_op;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mcs_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .step(step),
    .a_we(a_we), .b_we(b_we), .c_we(c_we), .pc_we(pc_we), .rf_we(rf_we),
    .ir_we(ir_we), .mdr_we(mdr_we), .mem_wr(mem_wr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wsel(rf_wsel),
    .pc_sel(pc_sel), .maddr_sel(maddr_sel), .use_z(use_z),
    .rd1_zero(rd1_zero), .wr_rt(wr_rt), .alu_op(alu_op)
  );

  // enable bits in the order {A, B, C, PC, RF, IR, MDR, MEMWR}
  localparam logic [7:0] EA = 8'h80, EB = 8'h40, EC = 8'h20, EP = 8'h10;
  localparam logic [7:0] ER = 8'h08, EI = 8'h04, EM = 8'h02, EW = 8'h01;

  logic [7:0]  act_we;
  logic [14:0] act_mx;
  assign act_we = {a_we, b_we, c_we, pc_we, rf_we, ir_we, mdr_we, mem_wr};
  assign act_mx = {alu_a_sel, alu_b_sel, rf_wsel, pc_sel, maddr_sel, use_z, rd1_zero, wr_rt, alu_op};

  function automatic logic [14:0] mx(input logic aa, input logic [1:0] bb,
      input logic rw, input logic ps, input logic [1:0] ma, input logic [1:0] uz,
      input logic r0, input logic rt, input logic [3:0] op);
    return {aa, bb, rw, ps, ma, uz, r0, rt, op};
  endfunction

  task automatic chk(input string req, input int k, input logic [7:0] we, input logic [14:0] m);
    n_chk++;
    if (step !== k[2:0] || act_we !== we || act_mx !== m) begin
      n_bad++;
      $display("FAIL %s op=%b: got step=%0d we=%h mx=%h, expected step=%0d we=%h mx=%h",
               req, opcode, step, act_we, act_mx, k, we, m);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    #1;
  endtask

  task automatic fetch(input logic [5:0] opc);
    opcode = opc;
    chk("R1", 0, EI | EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0));
    adv();
  endtask

  task automatic t_rtype(input logic [5:0] opc, input logic [3:0] op);
    fetch(opc);
    chk("R2", 1, EP | EA | EB, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R10", 2, EC, mx(0, 0, 0, 0, 0, 0, 0, 0, op)); adv();
    chk("R3", 3, ER, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
  endtask

  task automatic t_imm(input logic [5:0] opc, input logic [3:0] op);
    fetch(opc);
    chk("R4", 1, EP | EA | EM, mx(0, 0, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R4", 2, EC, mx(0, 1, 0, 0, 0, 0, 0, 0, op)); adv();
    chk("R4", 3, ER | EC, mx(1, 2, 0, 0, 0, 0, 0, 1, 0)); adv();
    chk("R4", 4, EP, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
  endtask

  task automatic t_ld();
    fetch(6'b100000);
    chk("R5", 1, EP | EA, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R5", 2, EM, mx(0, 0, 0, 0, 2, 0, 0, 0, 0)); adv();
    chk("R5", 3, ER, mx(0, 0, 1, 0, 0, 0, 0, 1, 0)); adv();
  endtask

  task automatic t_ldi();
    fetch(6'b100001);
    chk("R5", 1, EP | EA | EM, mx(0, 0, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R5", 2, EC, mx(0, 1, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R5", 3, EC | EM, mx(1, 2, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R5", 4, ER | EP, mx(0, 0, 1, 0, 0, 0, 0, 1, 0)); adv();
  endtask

  task automatic t_st();
    fetch(6'b100010);
    chk("R6", 1, EP | EA | EB, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R6", 2, EW, mx(0, 0, 0, 0, 2, 0, 0, 0, 0)); adv();
  endtask

  task automatic t_sti();
    fetch(6'b100011);
    chk("R6", 1, EP | EA | EM, mx(0, 0, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R6", 2, EC | EB, mx(0, 1, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R6", 3, EW | EC, mx(1, 2, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R6", 4, EP, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
  endtask

  task automatic t_brt(input logic [5:0] opc, input logic [1:0] uz);
    fetch(opc);
    chk("R7", 1, EP | EA | EB, mx(0, 0, 0, 0, 0, 0, 1, 0, 0)); adv();
    chk("R7", 2, EA, mx(0, 0, 0, 0, 0, 0, 0, 0, 4)); adv();
    chk("R7", 3, EP, mx(0, 0, 0, 1, 0, uz, 0, 0, 0)); adv();
  endtask

  task automatic t_brc(input logic [5:0] opc, input logic [1:0] uz);
    fetch(opc);
    chk("R8", 1, EP | EA | EB | EM, mx(0, 0, 0, 0, 1, 0, 0, 0, 0)); adv();
    chk("R8", 2, EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R8", 3, EP, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R8", 4, EC, mx(1, 1, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R11", 5, 8'h00, mx(0, 0, 0, 0, 0, 0, 0, 0, 4)); adv();
    chk("R8", 6, EP, mx(0, 0, 0, 0, 0, uz, 0, 0, 0)); adv();
  endtask

  task automatic t_bad(input logic [5:0] opc);
    fetch(opc);
    chk("R9", 1, EP, mx(0, 0, 0, 0, 0, 0, 0, 0, 0)); adv();
    chk("R9", 0, EI | EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_reset_mid();
    fetch(6'b110100);
    chk("R8", 1, EP | EA | EB | EM, mx(0, 0, 0, 0, 1, 0, 0, 0, 0)); adv();
    rst_n = 1'b0;
    #1;
    chk("R1", 0, EI | EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL R12 watchdog: got no completion, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", 0, EI | EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3 / R10 register forms
    t_rtype(6'b000000, 4'd0);
    t_rtype(6'b000001, 4'd1);
    t_rtype(6'b000010, 4'd2);
    t_rtype(6'b000011, 4'd3);
    t_rtype(6'b001000, 4'd4);
    t_rtype(6'b001100, 4'd5);
    // R4 immediate forms
    t_imm(6'b010000, 4'd0);
    t_imm(6'b010001, 4'd1);
    t_imm(6'b010010, 4'd2);
    t_imm(6'b010011, 4'd3);
    t_imm(6'b011000, 4'd4);
    t_ld();
    t_ldi();
    t_st();
    t_sti();
    t_brt(6'b110000, 2'd2);
    t_brt(6'b110001, 2'd1);
    t_brc(6'b110100, 2'd1);
    t_brc(6'b110101, 2'd2);
    // R9 unassigned opcodes from each quadrant
    t_bad(6'b000100);
    t_bad(6'b001101);
    t_bad(6'b011100);
    t_bad(6'b100100);
    t_bad(6'b110010);
    t_bad(6'b111111);
    t_reset_mid();
    t_brc(6'b110101, 2'd2);
    // R12 back at fetch after the last schedule
    chk("R12", 0, EI | EC, mx(1, 2, 0, 0, 0, 0, 0, 0, 0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule